// File: doc/BRIEF.md
# Timer Output-Compare Unit with Master Override

The block is the output-compare side of a general-purpose timer. A 16-bit counter advances by one on every clock. Each of eight channels holds a 16-bit compare value and a 2-bit pin action. When a channel is enabled for output compare and the counter equals its compare value, the channel applies its action to its own port pin and raises its interrupt flag. Software reaches every register through a byte-wide register bus that writes on a strobe and reads back combinationally.

Channel 7 is also a master compare. When it fires, every pin picked in an override mask takes the matching bit of an override data byte. This happens even when that pin's own channel acts in the same cycle. A strobe register fires chosen channels at once, with no interrupt flag. Setting a mask bit on an output-compare channel also turns that pin into an output, and the stored direction bit is left as it was.

Top module: `ocu_top`

## Requirements
- R1: After reset, `pin_out`, `pin_oe` and `irq_flag` are 0x00, and every register reads 0x00.
- R2: A channel fires when its select bit (register 0x00, bit n = channel n) is 1 and the counter equals its compare value. The compare value is at 0x10+2n (high byte) and 0x11+2n (low byte). One cycle later its pin shows the action. The action field for channel n is bits [2(n mod 4)+1 : 2(n mod 4)] of 0x05 (channels 0–3) or 0x06 (channels 4–7), with codes 00 hold, 01 invert, 10 drive 0, 11 drive 1. Pins that do not fire keep their value.
- R3: A compare match sets bit n of the flag register 0x07 (also on `irq_flag`). Writing 1 to a flag bit clears it. Writing 0 leaves it. A set and a clear in the same cycle leave the flag set.
- R4: A channel whose select bit is 0 neither changes its pin nor sets its flag on a counter match.
- R5: Writing a byte to 0x01 applies, one cycle later, the action of every selected channel whose bit in that byte is 1. No flag is set. Address 0x01 always reads 0x00.
- R6: `pin_oe[n]` is 1 when direction bit n (register 0x04) is 1, or when both select bit n and override mask bit n (0x02) are 1. Register 0x04 reads back exactly as written.
- R7: When selected channel 7 fires, by match or by strobe, every pin whose mask bit (0x02) is 1 takes the matching bit of the override data register (0x03) one cycle later.
- R8: When channel 7 and channel n fire in the same cycle and mask bit n is 1, pin n takes the data bit. An unmasked pin follows its own channel's action.
- R9: Registers 0x02 and 0x03 can be written and read back at any time.
- R10: The counter steps by one each cycle and wraps modulo 2^16. Its value is on `tcnt` and reads at 0x08 (high byte) and 0x09 (low byte).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| pin_out | output | 8 | Timer port pin levels |
| pin_oe | output | 8 | Effective pin direction (1 = output) |
| irq_flag | output | 8 | Per-channel compare flags |
| tcnt | output | 16 | Free-running counter value |

## Verification
The bench walks each action code across several channels. It checks the strobe path separately, because a design that routes the strobe through the match path would raise flags it must not raise. A flag clear is written in the exact cycle of a match: a design that gives the clear priority would lose the event. One cycle has channel 7 and channels 2, 3 and 5 all matching together. Masked pins must show the data byte against opposing drive-1 and drive-0 actions, while an unmasked pin still inverts. Two faulty designs are caught here: one that applies the priority in reverse, and one that drives all pins on a master fire. A final check confirms that setting a mask bit raises the output enable without disturbing the read-back direction register.

// File: rtl/ocu_pkg.sv
// Shared constants, action encoding and register offsets for the
// output-compare unit. Assumes a byte-wide register bus with one bit
// per channel in each control byte.
package ocu_pkg;
    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned CH_N      = BYTE_W;
    localparam int unsigned MASTER_CH = CH_N - 1;
    localparam int unsigned ADDR_W    = 5;
    localparam int unsigned CMP_BYTES = 2;
    localparam int unsigned PAD_W     = CMP_BYTES * BYTE_W;
    localparam int unsigned ACT_W     = 2;
    localparam int unsigned ACT_PER_B = BYTE_W / ACT_W;

    typedef enum logic [ACT_W-1:0] {
        ACT_HOLD   = 2'b00,
        ACT_INVERT = 2'b01,
        ACT_LOW    = 2'b10,
        ACT_HIGH   = 2'b11
    } oc_act_e;

    localparam logic [ADDR_W-1:0] A_SEL      = 5'h00;
    localparam logic [ADDR_W-1:0] A_STROBE   = 5'h01;
    localparam logic [ADDR_W-1:0] A_OVR_MASK = 5'h02;
    localparam logic [ADDR_W-1:0] A_OVR_DATA = 5'h03;
    localparam logic [ADDR_W-1:0] A_DIR      = 5'h04;
    localparam logic [ADDR_W-1:0] A_ACT_LO   = 5'h05;
    localparam logic [ADDR_W-1:0] A_ACT_HI   = 5'h06;
    localparam logic [ADDR_W-1:0] A_FLAG     = 5'h07;
    localparam logic [ADDR_W-1:0] A_CNT_HI   = 5'h08;
    localparam logic [ADDR_W-1:0] A_CNT_LO   = 5'h09;
    localparam logic [ADDR_W-1:0] A_CMP_BASE = 5'h10;

    // Next pin level produced by an action applied to the current level.
    function automatic logic apply_act(input oc_act_e act, input logic cur);
        case (act)
            ACT_INVERT: return ~cur;
            ACT_LOW:    return 1'b0;
            ACT_HIGH:   return 1'b1;
            default:    return cur;
        endcase
    endfunction
endpackage

// File: rtl/ocu_counter.sv
// Free-running up counter for the timer. It wraps modulo 2^CNT_W and has
// no enable input: it advances on every clock once out of reset.
module ocu_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt_q
);
    // Advance the count by one each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/ocu_regs.sv
// Register file and read mux for the output-compare unit. Holds the
// select, override mask/data, direction, action and compare registers.
// Produces the one-cycle strobe and flag-clear vectors from bus writes.
// Assumes 9 <= CNT_W <= 16, so a compare value spans two bytes (high first).
module ocu_regs
    import ocu_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_wr,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [BYTE_W-1:0]            bus_wdata,
    input  logic [CH_N-1:0]              flags,
    input  logic [CNT_W-1:0]             cnt,
    output logic [BYTE_W-1:0]            bus_rdata,
    output logic [CH_N-1:0]              sel_q,
    output logic [CH_N-1:0]              mask_q,
    output logic [CH_N-1:0]              data_q,
    output logic [CH_N-1:0]              dir_q,
    output logic [CH_N-1:0][ACT_W-1:0]   act_q,
    output logic [CH_N-1:0][CNT_W-1:0]   cmp_q,
    output logic [CH_N-1:0]              strobe,
    output logic [CH_N-1:0]              flag_clr
);
    localparam int unsigned CH_IDX_W = $clog2(CH_N);

    logic [CH_N-1:0][PAD_W-1:0] cmp_pad;
    logic [PAD_W-1:0]           cnt_pad;
    logic [CH_IDX_W-1:0]        rd_ch;
    logic                       wr_cmp;

    // Decode the write-only strobes that last exactly one cycle.
    always_comb begin
        strobe   = (bus_wr && bus_addr == A_STROBE) ? bus_wdata : '0;
        flag_clr = (bus_wr && bus_addr == A_FLAG)   ? bus_wdata : '0;
        wr_cmp   = bus_wr && (bus_addr >= A_CMP_BASE);
    end

    // Store the byte-wide control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= '0;
            mask_q <= '0;
            data_q <= '0;
            dir_q  <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                A_SEL:      sel_q  <= bus_wdata;
                A_OVR_MASK: mask_q <= bus_wdata;
                A_OVR_DATA: data_q <= bus_wdata;
                A_DIR:      dir_q  <= bus_wdata;
                default: ;
            endcase
        end
    end

    // Per-channel action fields and compare registers, one slice per channel.
    for (genvar n = 0; n < CH_N; n++) begin : g_ch_regs
        localparam logic [ADDR_W-1:0] ACT_ADDR =
            ADDR_W'(int'(A_ACT_LO) + n / ACT_PER_B);
        localparam int unsigned ACT_LSB = ACT_W * (n % ACT_PER_B);
        localparam logic [ADDR_W-1:0] CMP_HI =
            ADDR_W'(int'(A_CMP_BASE) + CMP_BYTES * n);
        localparam logic [ADDR_W-1:0] CMP_LO = CMP_HI + 1'b1;

        // Capture this channel's action field from its shared byte.
        always_ff @(posedge clk) begin
            if (!rst_n)                            act_q[n] <= '0;
            else if (bus_wr && bus_addr == ACT_ADDR) act_q[n] <= bus_wdata[ACT_LSB +: ACT_W];
        end

        // Capture this channel's compare bytes.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cmp_pad[n] <= '0;
            end else if (wr_cmp && bus_addr == CMP_HI) begin
                cmp_pad[n][BYTE_W +: BYTE_W] <= bus_wdata;
            end else if (wr_cmp && bus_addr == CMP_LO) begin
                cmp_pad[n][0 +: BYTE_W] <= bus_wdata;
            end
        end

        assign cmp_q[n] = cmp_pad[n][CNT_W-1:0];
    end

    // Zero-extend the counter for byte reads.
    always_comb begin
        cnt_pad            = '0;
        cnt_pad[CNT_W-1:0] = cnt;
    end

    assign rd_ch = bus_addr[CH_IDX_W:1];

    // Combinational read mux; the strobe address always returns zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr >= A_CMP_BASE) begin
            bus_rdata = bus_addr[0] ? cmp_pad[rd_ch][0 +: BYTE_W]
                                    : cmp_pad[rd_ch][BYTE_W +: BYTE_W];
        end else begin
            case (bus_addr)
                A_SEL:      bus_rdata = sel_q;
                A_OVR_MASK: bus_rdata = mask_q;
                A_OVR_DATA: bus_rdata = data_q;
                A_DIR:      bus_rdata = dir_q;
                A_ACT_LO:   bus_rdata = act_q[ACT_PER_B-1:0];
                A_ACT_HI:   bus_rdata = act_q[CH_N-1:ACT_PER_B];
                A_FLAG:     bus_rdata = flags;
                A_CNT_HI:   bus_rdata = cnt_pad[BYTE_W +: BYTE_W];
                A_CNT_LO:   bus_rdata = cnt_pad[0 +: BYTE_W];
                default:    bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/ocu_channel.sv
// One compare channel: detects an equality match against the counter,
// merges it with the strobe into a fire signal, and computes the pin level
// its action would produce. Purely combinational; a deselected channel
// never matches or fires.
module ocu_channel
    import ocu_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp,
    input  logic             sel,
    input  logic             strobe,
    input  logic [ACT_W-1:0] act,
    input  logic             cur_pin,
    output logic             match,
    output logic             fire,
    output logic             next_val
);
    // Match, fire and resulting pin level for this channel.
    always_comb begin
        match    = sel && (cnt == cmp);
        fire     = match || (sel && strobe);
        next_val = apply_act(oc_act_e'(act), cur_pin);
    end
endmodule

// File: rtl/ocu_pin_ctrl.sv
// Pin and flag state. Resolves, per pin, the master channel's override
// against the pin's own channel action (override wins on masked pins),
// and keeps the sticky flags where a same-cycle set beats a clear.
module ocu_pin_ctrl
    import ocu_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CH_N-1:0] fire,
    input  logic [CH_N-1:0] next_val,
    input  logic [CH_N-1:0] match,
    input  logic [CH_N-1:0] mask,
    input  logic [CH_N-1:0] data,
    input  logic [CH_N-1:0] flag_clr,
    output logic [CH_N-1:0] pin_q,
    output logic [CH_N-1:0] flags_q
);
    logic [CH_N-1:0] ovr;

    // Pins taken over by the master channel this cycle.
    assign ovr = {CH_N{fire[MASTER_CH]}} & mask;

    // Update each pin from the override data or its own channel action.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q <= '0;
        end else begin
            for (int n = 0; n < CH_N; n++) begin
                if (ovr[n])       pin_q[n] <= data[n];
                else if (fire[n]) pin_q[n] <= next_val[n];
            end
        end
    end

    // Sticky flags: set on match, clear on write-one, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~flag_clr) | match;
    end
endmodule

// File: rtl/ocu_top.sv
// Eight-channel output-compare unit. Ties together the counter, register
// file, compare channels and pin/flag state, and derives the effective
// pin direction. Assumes synchronous active-low reset and 9 <= CNT_W <= 16.
module ocu_top
    import ocu_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [4:0]        bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic [7:0]        pin_out,
    output logic [7:0]        pin_oe,
    output logic [7:0]        irq_flag,
    output logic [CNT_W-1:0]  tcnt
);
    logic [CNT_W-1:0]            cnt_q;
    logic [CH_N-1:0]             sel_q, mask_q, data_q, dir_q;
    logic [CH_N-1:0][ACT_W-1:0]  act_q;
    logic [CH_N-1:0][CNT_W-1:0]  cmp_q;
    logic [CH_N-1:0]             strobe, flag_clr;
    logic [CH_N-1:0]             match_v, fire_v, next_v;
    logic [CH_N-1:0]             pin_q, flags_q;

    ocu_counter #(.CNT_W(CNT_W)) i_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt_q (cnt_q)
    );

    ocu_regs #(.CNT_W(CNT_W)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .flags     (flags_q),
        .cnt       (cnt_q),
        .bus_rdata (bus_rdata),
        .sel_q     (sel_q),
        .mask_q    (mask_q),
        .data_q    (data_q),
        .dir_q     (dir_q),
        .act_q     (act_q),
        .cmp_q     (cmp_q),
        .strobe    (strobe),
        .flag_clr  (flag_clr)
    );

    for (genvar n = 0; n < CH_N; n++) begin : g_chan
        ocu_channel #(.CNT_W(CNT_W)) i_chan (
            .cnt      (cnt_q),
            .cmp      (cmp_q[n]),
            .sel      (sel_q[n]),
            .strobe   (strobe[n]),
            .act      (act_q[n]),
            .cur_pin  (pin_q[n]),
            .match    (match_v[n]),
            .fire     (fire_v[n]),
            .next_val (next_v[n])
        );
    end

    ocu_pin_ctrl i_pins (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire_v),
        .next_val (next_v),
        .match    (match_v),
        .mask     (mask_q),
        .data     (data_q),
        .flag_clr (flag_clr),
        .pin_q    (pin_q),
        .flags_q  (flags_q)
    );

    // Drive the outputs; a masked output-compare pin is always an output.
    always_comb begin
        pin_out  = pin_q;
        pin_oe   = dir_q | (sel_q & mask_q);
        irq_flag = flags_q;
        tcnt     = cnt_q;
    end
endmodule

// File: rtl/ocu_checker.sv
// Temporal checks on the output-compare unit, bound into every ocu_top.
module ocu_checker #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [4:0]       bus_addr,
    input logic             bus_wr,
    input logic [7:0]       bus_rdata,
    input logic [7:0]       bus_wdata,
    input logic [7:0]       pin,
    input logic [7:0]       sel,
    input logic [7:0]       mask,
    input logic [7:0]       data,
    input logic [7:0]       flags,
    input logic [7:0]       match,
    input logic             master_fire,
    input logic [CNT_W-1:0] cnt
);
    // R10: counter advances by exactly one, wrapping.
    a_r10_counter_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cnt == CNT_W'($past(cnt) + 1'b1));

    // R3: a flag only falls after a write-one to the flag register.
    a_r3_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == 5'h07) |=> (($past(flags) & ~flags) == 8'h00));

    // R5: a flag only rises after a real compare match, never a strobe.
    a_r5_flag_only_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((flags & ~$past(flags)) & ~$past(match)) == 8'h00));

    // R5: the strobe address reads as zero.
    a_r5_strobe_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr == 5'h01 |-> bus_rdata == 8'h00);

    // R8: after a master fire, masked pins equal the override data.
    a_r8_master_override: assert property (@(posedge clk) disable iff (!rst_n)
        master_fire |=> (((pin ^ $past(data)) & $past(mask)) == 8'h00));

    // R4: a pin neither selected nor overridden does not move.
    a_r4_idle_pin_holds: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((pin ^ $past(pin)) & ~$past(sel)
                   & ~($past(mask) & {8{$past(master_fire)}})) == 8'h00));

    // R9: a write to the mask register is visible in the next cycle.
    a_r9_mask_written: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 5'h02) |=> mask == $past(bus_wdata));
endmodule

bind ocu_top ocu_checker #(.CNT_W(CNT_W)) i_ocu_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_rdata   (bus_rdata),
    .bus_wdata   (bus_wdata),
    .pin         (pin_q),
    .sel         (sel_q),
    .mask        (mask_q),
    .data        (data_q),
    .flags       (flags_q),
    .match       (match_v),
    .master_fire (fire_v[7]),
    .cnt         (cnt_q)
);

// File: tb/test_ocu_top.sv
// Self-checking bench for ocu_top: a vector table of single-channel
// compare actions, then directed tests for strobe, flags, direction
// and master override.
module test_ocu_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata, pin_out, pin_oe, irq_flag;
    logic [15:0] tcnt;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [7:0]      sel_m = '0;
    logic [7:0][1:0] act_m = '0;
    logic [7:0]      rv;
    logic [15:0]     tgt;

    // Vector: {channel[2:0], action[1:0], expected pin level}
    localparam int NV = 10;
    localparam logic [5:0] VEC [NV] = '{
        {3'd0, 2'b11, 1'b1}, {3'd0, 2'b01, 1'b0}, {3'd0, 2'b01, 1'b1},
        {3'd0, 2'b10, 1'b0}, {3'd3, 2'b00, 1'b0}, {3'd3, 2'b11, 1'b1},
        {3'd5, 2'b01, 1'b1}, {3'd6, 2'b11, 1'b1}, {3'd6, 2'b10, 1'b0},
        {3'd2, 2'b11, 1'b1}
    };

    ocu_top i_ocu_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .irq_flag  (irq_flag),
        .tcnt      (tcnt)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic set_act(input int ch, input logic [1:0] a);
        act_m[ch] = a;
        if (ch < 4) wr(5'h05, act_m[3:0]);
        else        wr(5'h06, act_m[7:4]);
    endtask

    task automatic set_cmp(input int ch, input logic [15:0] v);
        wr(5'(5'h10 + 2 * ch), v[15:8]);
        wr(5'(5'h11 + 2 * ch), v[7:0]);
    endtask

    task automatic wait_cnt(input logic [15:0] v);
        while (tcnt !== v) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 pin_out", 16'(pin_out), 16'h00);
        chk("R1 pin_oe", 16'(pin_oe), 16'h00);
        chk("R1 irq_flag", 16'(irq_flag), 16'h00);
        rd(5'h02, rv); chk("R1 mask", 16'(rv), 16'h00);
        rd(5'h03, rv); chk("R1 data", 16'(rv), 16'h00);
        rd(5'h00, rv); chk("R1 sel", 16'(rv), 16'h00);

        // R2 R3: table of single-channel compare actions
        for (int i = 0; i < NV; i++) begin
            int ch;
            ch = int'(VEC[i][5:3]);
            sel_m[ch] = 1'b1;
            wr(5'h00, sel_m);
            set_act(ch, VEC[i][2:1]);
            tgt = tcnt + 16'd30;
            set_cmp(ch, tgt);
            wait_cnt(tgt);
            @(negedge clk);
            chk("R2 action pin", 16'(pin_out[ch]), 16'(VEC[i][0]));
            chk("R3 flag on match", 16'(irq_flag[ch]), 16'h1);
            wr(5'h07, 8'(1 << ch));
            chk("R3 flag cleared", 16'(irq_flag[ch]), 16'h0);
        end
        chk("R2 other pins kept", 16'(pin_out), 16'h2C);

        // R4: unselected channel matches with no effect
        set_act(1, 2'b11);
        tgt = tcnt + 16'd30;
        set_cmp(1, tgt);
        wait_cnt(tgt);
        @(negedge clk); @(negedge clk);
        chk("R4 unselected pin", 16'(pin_out), 16'h2C);
        chk("R4 unselected flag", 16'(irq_flag), 16'h00);

        // R5: strobe fires action without flag
        sel_m[1] = 1'b1;
        wr(5'h00, sel_m);
        wr(5'h01, 8'h02);
        chk("R5 strobe action", 16'(pin_out), 16'h2E);
        chk("R5 strobe no flag", 16'(irq_flag), 16'h00);
        rd(5'h01, rv); chk("R5 strobe reads zero", 16'(rv), 16'h00);

        // R3: clear in the match cycle loses to set; write-0 no effect
        set_act(0, 2'b01);
        tgt = tcnt + 16'd30;
        set_cmp(0, tgt);
        wait_cnt(tgt);
        wr(5'h07, 8'h01);
        chk("R3 set beats clear", 16'(irq_flag), 16'h01);
        chk("R2 invert in clear cycle", 16'(pin_out), 16'h2F);
        wr(5'h07, 8'h00);
        chk("R3 write zero keeps flag", 16'(irq_flag), 16'h01);
        wr(5'h07, 8'h01);
        chk("R3 write one clears", 16'(irq_flag), 16'h00);

        // R6: direction and mask-driven output enable
        wr(5'h04, 8'h01);
        chk("R6 dir only", 16'(pin_oe), 16'h01);
        wr(5'h02, 8'h90);
        chk("R6 mask on unselected", 16'(pin_oe), 16'h01);
        sel_m[7] = 1'b1;
        wr(5'h00, sel_m);
        chk("R6 mask on selected", 16'(pin_oe), 16'h81);
        rd(5'h04, rv); chk("R6 dir unchanged", 16'(rv), 16'h01);
        rd(5'h02, rv); chk("R9 mask readback", 16'(rv), 16'h90);

        // R7 R8: master and channels 2,3,5 match together
        tgt = tcnt + 16'd80;
        wr(5'h02, 8'h1C);
        wr(5'h03, 8'h14);
        set_act(7, 2'b00);
        set_act(2, 2'b10);
        set_act(3, 2'b11);
        set_act(5, 2'b01);
        set_cmp(7, tgt);
        set_cmp(2, tgt);
        set_cmp(3, tgt);
        set_cmp(5, tgt);
        chk("R6 oe with mask 1C", 16'(pin_oe), 16'h0D);
        wait_cnt(tgt);
        @(negedge clk);
        chk("R8 override priority", 16'(pin_out), 16'h17);
        chk("R8 flags of all matches", 16'(irq_flag), 16'hAC);

        // R7: strobe on the master applies override data
        wr(5'h07, 8'hFF);
        wr(5'h03, 8'h08);
        wr(5'h01, 8'h80);
        chk("R7 master strobe override", 16'(pin_out), 16'h0B);
        chk("R7 master strobe no flag", 16'(irq_flag), 16'h00);
        rd(5'h02, rv); chk("R9 mask readback", 16'(rv), 16'h1C);
        rd(5'h03, rv); chk("R9 data readback", 16'(rv), 16'h08);

        // R10: counter steps and byte reads
        begin
            logic [15:0] c0;
            c0 = tcnt;
            @(negedge clk);
            chk("R10 counter step", tcnt, c0 + 16'd1);
            rd(5'h08, rv); chk("R10 count high", 16'(rv), 16'(tcnt[15:8]));
            rd(5'h09, rv); chk("R10 count low", 16'(rv), 16'(tcnt[7:0]));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule